// File: doc/BRIEF.md
# LCD Blink Timing Generator

This block sets the blink rhythm of a segment LCD controller. A divider counts enabled clock ticks. It turns them into a square-wave blink phase whose full period is 768, 1536 or 3072 ticks, chosen by a two-bit rate code. A fourth code value turns blinking off, so the display is shown all the time.

The phase drives the display in one of two ways. In normal mode the segments are blanked during the low half of each period. In alternate-bank mode the output bank selection is flipped during the high half instead. This swaps which of two RAM banks is shown, and no blanking is done. Bank alternation only makes sense when the panel leaves spare RAM rows. It is therefore honoured only with the static or two-backplane multiplex setting. With three or four backplanes, alternate mode falls back to normal blanking.

A change of the rate code restarts the divider, so the first period at the new rate begins at its start.

Top module: `lcd_blink_gen`

## Requirements
- R1: After a synchronous active-low reset with rate code 00 applied, `blank` and `bank_flip` are both 0.
- R2: Rate code 01 gives a blink period of 768 enabled ticks: 384 ticks with the phase low, followed by 384 ticks with the phase high.
- R3: Rate code 10 gives a blink period of 1536 enabled ticks, split into two equal halves of 768.
- R4: Rate code 11 gives a blink period of 3072 enabled ticks, split into two equal halves of 1536, and the divider never reaches 3072.
- R5: Rate code 00 holds `blank` and `bank_flip` at 0 from the following cycle, whatever the mode inputs are.
- R6: In normal mode (`alt_mode` = 0), `blank` is 1 exactly while the phase is low, and `bank_flip` stays 0.
- R7: In alternate mode (`alt_mode` = 1) with `mux_mode` 00 (static) or 01 (two backplanes), `bank_flip` is 1 exactly while the phase is high, and `blank` stays 0.
- R8: In alternate mode with `mux_mode` 10 (three backplanes) or 11 (four backplanes), the block behaves as in normal mode, and `bank_flip` stays 0.
- R9: When the rate code differs from the one applied in the previous cycle, the divider is cleared at the next clock edge, so a fresh period starts with the phase low.
- R10: Cycles with `tick` = 0 do not advance the divider, and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Display clock tick enable; one divider step per cycle when high |
| freq_code | input | 2 | Blink rate: 00 off, 01 /768, 10 /1536, 11 /3072 |
| alt_mode | input | 1 | 0 normal blanking, 1 alternate-bank blinking |
| mux_mode | input | 2 | Drive setting: 00 static, 01 two, 10 three, 11 four backplanes |
| blank | output | 1 | Force segment outputs off |
| bank_flip | output | 1 | Invert the output RAM bank selection |

## Verification
The assertions assume the following about the inputs:
- The rate code applies from the clock edge after it changes.
- The mode inputs act on the outputs in the same cycle.
- The divider moves only on enabled ticks while the rate code is steady.

The bench changes inputs only between edges. It runs every rate code through full periods, using a continuous tick and irregular tick gaps. It also covers every combination of mode bit and backplane setting, and switches rates in the middle of a period. It measures the phase run lengths against the arithmetic values 384, 768 and 1536.

// File: rtl/lcd_blink_pkg.sv
// Package: shared encodings for the LCD blink timing generator.
// Assumes a two-bit rate code and a two-bit backplane count code.
package lcd_blink_pkg;

    typedef enum logic [1:0] {
        RATE_OFF  = 2'b00,
        RATE_DIV1 = 2'b01,
        RATE_DIV2 = 2'b10,
        RATE_DIV4 = 2'b11
    } blink_rate_e;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'b00,
        MUX_TWO    = 2'b01,
        MUX_THREE  = 2'b10,
        MUX_FOUR   = 2'b11
    } mux_sel_e;

    // Full blink period in ticks for a rate code; base is the fastest period.
    function automatic int unsigned rate_period(input logic [1:0] code, input int unsigned base);
        if (code == RATE_OFF) return 0;
        return base << (int'(code) - 1);
    endfunction

endpackage

// File: rtl/blink_divider.sv
// Module: tick counter that wraps at a supplied terminal value.
// Assumes 'last' is stable while counting; 'clear' has priority over 'adv'.
module blink_divider #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt
);

    // Count enabled ticks, wrap after 'last', restart on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/blink_phase_sel.sv
// Module: per-rate terminal and half-period table, and phase decode.
// Assumes rate code 00 means blinking off; each other code doubles the period.
module blink_phase_sel
    import lcd_blink_pkg::*;
#(
    parameter int unsigned BASE_DIV = 768,
    parameter int unsigned CNT_W    = 12
) (
    input  logic [1:0]       code,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] last,
    output logic             phase
);

    logic [CNT_W-1:0] last_tab [4];
    logic [CNT_W-1:0] half_tab [4];

    assign last_tab[0] = '0;
    assign half_tab[0] = '0;

    // One table entry per rate code, derived from the base period.
    generate
        for (genvar r = 1; r < 4; r++) begin : g_rate
            localparam int unsigned PER = rate_period(2'(r), BASE_DIV);
            assign last_tab[r] = CNT_W'(PER - 1);
            assign half_tab[r] = CNT_W'(PER / 2);
        end
    endgenerate

    // Select the terminal count and decode the square-wave phase.
    always_comb begin
        last  = last_tab[code];
        phase = (code != RATE_OFF) && (cnt >= half_tab[code]);
    end

endmodule

// File: rtl/blink_output_map.sv
// Module: maps the blink phase to blanking or bank inversion.
// Assumes bank alternation is only meaningful with one or two backplanes.
module blink_output_map
    import lcd_blink_pkg::*;
(
    input  logic       enable,
    input  logic       phase,
    input  logic       alt_mode,
    input  logic [1:0] mux_mode,
    output logic       blank,
    output logic       bank_flip
);

    logic alt_ok;

    // Decide the effective mode, then drive exactly one of the two outputs.
    always_comb begin
        alt_ok    = alt_mode && ((mux_mode == MUX_STATIC) || (mux_mode == MUX_TWO));
        blank     = enable && !phase && !alt_ok;
        bank_flip = enable &&  phase &&  alt_ok;
    end

endmodule

// File: rtl/lcd_blink_gen.sv
// Module: LCD blink timing generator top.
// Divides enabled ticks by 768/1536/3072 (default base) to form a blink phase,
// then blanks the segments or flips the bank. Assumes synchronous active-low reset.
module lcd_blink_gen
    import lcd_blink_pkg::*;
#(
    parameter int unsigned BASE_DIV = 768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] freq_code,
    input  logic       alt_mode,
    input  logic [1:0] mux_mode,
    output logic       blank,
    output logic       bank_flip
);

    localparam int unsigned MAX_PERIOD = BASE_DIV * 4;
    localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

    logic [1:0]       code_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             phase;
    logic             code_chg;
    logic             adv;

    // Register the rate code so a change is seen for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= RATE_OFF;
        else        code_q <= freq_code;
    end

    assign code_chg = (freq_code != code_q);
    assign adv      = tick && (code_q != RATE_OFF);

    blink_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (code_chg),
        .adv   (adv),
        .last  (last),
        .cnt   (cnt)
    );

    blink_phase_sel #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_phase (
        .code  (code_q),
        .cnt   (cnt),
        .last  (last),
        .phase (phase)
    );

    blink_output_map u_map (
        .enable    (code_q != RATE_OFF),
        .phase     (phase),
        .alt_mode  (alt_mode),
        .mux_mode  (mux_mode),
        .blank     (blank),
        .bank_flip (bank_flip)
    );

endmodule

// File: rtl/lcd_blink_gen_chk.sv
// Module: property checker for lcd_blink_gen, attached by bind.
// Assumes inputs change between clock edges only.
module lcd_blink_gen_chk #(
    parameter int unsigned BASE_DIV = 768,
    parameter int unsigned CNT_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       freq_code,
    input logic             alt_mode,
    input logic [1:0]       mux_mode,
    input logic             blank,
    input logic             bank_flip,
    input logic [1:0]       code_q,
    input logic [CNT_W-1:0] cnt
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code == 2'b00) |=> (!blank && !bank_flip)); // R5

    AST_ALT_NO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_mode && !mux_mode[1]) |-> !blank); // R7

    AST_NORMAL_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode || mux_mode[1]) |-> !bank_flip); // R8

    AST_RATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != code_q) |=> (cnt == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && (freq_code == code_q)) |=> $stable(cnt)); // R10

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < int'(BASE_DIV * 4)); // R4

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(blank && bank_flip)); // R6

endmodule

bind lcd_blink_gen lcd_blink_gen_chk #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .freq_code (freq_code),
    .alt_mode  (alt_mode),
    .mux_mode  (mux_mode),
    .blank     (blank),
    .bank_flip (bank_flip),
    .code_q    (code_q),
    .cnt       (cnt)
);

// File: tb/lcd_blink_gen_tb.sv
module lcd_blink_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] freq_code = 2'b00;
    logic       alt_mode = 1'b0;
    logic [1:0] mux_mode = 2'b00;
    logic       blank;
    logic       bank_flip;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Arithmetic model state: rate code seen and enabled ticks into the period.
    int m_code = 0;
    int m_n = 0;

    always #2.5 clk = ~clk;

    lcd_blink_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .freq_code (freq_code),
        .alt_mode  (alt_mode),
        .mux_mode  (mux_mode),
        .blank     (blank),
        .bank_flip (bank_flip)
    );

    function automatic int period_of(input int c);
        return (c == 0) ? 0 : 768 * (1 << (c - 1));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One clock: update the model at the edge, then compare at the falling edge.
    task automatic cyc(input logic t, input string tag = "");
        bit   ph;
        bit   alt_eff;
        int   eb;
        int   ef;
        string tg;
        tick = t;
        @(posedge clk);
        if (!rst_n) begin
            m_code = 0; m_n = 0;
        end else if (int'(freq_code) != m_code) begin
            m_code = int'(freq_code); m_n = 0;
        end else if (t && m_code != 0) begin
            m_n = (m_n + 1) % period_of(m_code);
        end
        @(negedge clk);
        if (!rst_n) return;
        ph      = (m_code != 0) && (m_n >= period_of(m_code) / 2);
        alt_eff = alt_mode && (mux_mode < 2);
        eb = (m_code != 0 && !ph && !alt_eff) ? 1 : 0;
        ef = (m_code != 0 &&  ph &&  alt_eff) ? 1 : 0;
        if (tag != "")          tg = tag;
        else if (m_code == 0)   tg = "R5";
        else if (!t)            tg = "R10";
        else if (alt_eff)       tg = "R7";
        else if (alt_mode)      tg = "R8";
        else                    tg = "R6";
        chk({tg, " blank"}, int'(blank), eb);
        chk({tg, " bank_flip"}, int'(bank_flip), ef);
    endtask

    // Set a rate, then measure the phase-low and phase-high run lengths in normal mode.
    task automatic measure(input logic [1:0] code, input string tag);
        int hi = 0;
        int lo = 0;
        freq_code = code;
        cyc(1'b1, tag);
        while (blank && hi < 5000) begin hi++; cyc(1'b1); end
        while (!blank && lo < 5000) begin lo++; cyc(1'b1); end
        chk({tag, " low-half length"}, hi, period_of(int'(code)) / 2);
        chk({tag, " high-half length"}, lo, period_of(int'(code)) / 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic snap;
        // R1: reset state with blinking off
        rst_n = 1'b0;
        repeat (3) cyc(1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 blank after reset", int'(blank), 0);
        chk("R1 bank_flip after reset", int'(bank_flip), 0);
        cyc(1'b1, "R1");

        // R2, R3, R4: period lengths in normal mode, static drive
        measure(2'b01, "R2");
        measure(2'b10, "R3");
        measure(2'b11, "R4");

        // R5: rate off with every mode combination
        freq_code = 2'b00;
        for (int m = 0; m < 8; m++) begin
            alt_mode = m[0];
            mux_mode = 2'(m >> 1);
            repeat (6) cyc(1'b1, "R5");
        end

        // R7: alternate bank with static and two-backplane drive
        alt_mode = 1'b1;
        mux_mode = 2'b00;
        freq_code = 2'b01;
        repeat (1600) cyc(1'b1);
        mux_mode = 2'b01;
        repeat (800) cyc(1'b1);

        // R8: alternate request with three and four backplanes falls back to blanking
        mux_mode = 2'b10;
        repeat (800) cyc(1'b1);
        mux_mode = 2'b11;
        repeat (800) cyc(1'b1);

        // R6: normal mode across all backplane settings
        alt_mode = 1'b0;
        for (int m = 0; m < 4; m++) begin
            mux_mode = 2'(m);
            repeat (400) cyc(1'b1);
        end

        // R10: irregular tick gaps at the middle rate
        mux_mode = 2'b00;
        freq_code = 2'b10;
        for (int i = 0; i < 4000; i++) cyc((i % 3) != 0);
        snap = blank;
        repeat (100) cyc(1'b0, "R10");
        chk("R10 blank held over idle", int'(blank), int'(snap));

        // R9: rate change mid-period restarts with the phase low
        freq_code = 2'b01;
        repeat (600) cyc(1'b1);
        chk("R9 high phase before switch", int'(blank), 0);
        measure(2'b11, "R9");
        alt_mode = 1'b1;
        freq_code = 2'b01;
        repeat (500) cyc(1'b1);
        freq_code = 2'b10;
        cyc(1'b1, "R9");
        chk("R9 alt mode flip cleared on switch", int'(bank_flip), 0);
        repeat (800) cyc(1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule